// File: doc/BRIEF.md
# Bit Test-Branch and Bit-Set Sequencer

This block executes two bit-manipulation instructions of a small 8-bit core. One tests a single bit of a memory byte and branches relative to the program counter when that bit is 1. The other forces a single bit of a memory byte to 1 and writes the byte back. The core hands over its program counter, index register value and carry flag together with a start pulse. The block then fetches the instruction bytes and the target byte over one byte-wide synchronous memory port. It reports the next program counter and the carry flag in the cycle its done strobe is high.

The bit number is coded in the opcode, and the operand is always an 8-bit direct address. Two operand values have a special meaning. One value redirects the access to the byte whose address is held in the index register. The other value reaches the index register itself, which sits at that address in the memory map. Every form, including an unrecognised opcode, takes the same five cycles.

Top module: `bitop_unit`

## Requirements
- R1: Memory reads are issued one per cycle with read data one cycle later. The order is: the opcode at PC, the direct address at PC+1, then (test-branch only) the offset at PC+2, then the target byte at the effective address. A set-bit reads only PC, PC+1 and the target. Read and write are never asserted together.
- R2: `done` is high for exactly one cycle: the fifth cycle after the clock edge that accepts `start`.
- R3: Opcode 0x00+2n (n = 0..7) tests bit n of the target. When that bit is 1, `pc_out` = PC + 3 + sign-extended offset modulo 2^ADDR_W, and `c_out` = 1.
- R4: When the tested bit is 0, `pc_out` = PC + 3 and `c_out` = 0, whatever the carry input was.
- R5: Opcode 0x10+2n writes (target | (1<<n)) back to the effective address in the `done` cycle. It then gives `pc_out` = PC + 2 and returns the captured carry unchanged. No write occurs in any other cycle.
- R6: A direct address of 0x0E makes the effective address equal to the index register value, zero-extended. The index register is not modified.
- R7: A direct address of 0x0F is used as the effective address unchanged, so the index register location itself is read and, for set-bit, written.
- R8: `start` is ignored while an instruction is in progress, even when held high across several cycles.
- R9: Any opcode other than the sixteen above raises `illegal` with `done`, performs no write and no read beyond PC and PC+1. It returns `pc_out` = PC and the captured carry.
- R10: After reset the block is idle: `done` is low and no memory access is issued until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one instruction when idle |
| pc_in | input | ADDR_W | Address of the opcode byte |
| x_in | input | 8 | Index register value |
| c_in | input | 1 | Carry flag before the instruction |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| done | output | 1 | Completion strobe |
| pc_out | output | ADDR_W | Next program counter, valid with `done` |
| c_out | output | 1 | Carry flag after the instruction, valid with `done` |
| illegal | output | 1 | Unrecognised opcode, valid with `done` |

## Verification
The bench goes after a branch whose offset is -128 and a branch whose operand bytes straddle the top of the address space. A design that zero-extends the offset or adds at a wider width would land on the wrong program counter. Redirection through address 0x0E and direct use of 0x0F are driven with an index value that differs from 0x0F, so mixing up the two special addresses produces a visibly wrong read or write address. Illegal opcodes adjacent to legal ones (odd values, 0x1F, 0x20) expose a loose decode as a spurious write. A start held high across the busy window exposes a sequencer that re-arms early, which would show up as a second `done`.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH_OP,
      ST_FETCH_DIR,
      ST_FETCH_OFF,
      ST_READ_DATA,
      ST_FINISH
   } bitop_state_t;

   typedef enum logic [1:0] {
      K_BRANCH,
      K_SETBIT,
      K_ILLEGAL
   } bitop_kind_t;

   localparam logic [7:0] BRANCH_BASE = 8'h00;
   localparam logic [7:0] SETBIT_BASE = 8'h10;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
   import bitop_pkg::*;
(
   input  logic [7:0]  opcode,
   output bitop_kind_t kind,
   output logic [2:0]  bit_idx
);

   logic group_ok;

   // Legal opcodes are even and lie in 0x00..0x1F (R3, R5, R9)
   assign group_ok = (opcode[7:5] == 3'b000) && (opcode[0] == 1'b0);
   assign bit_idx  = opcode[3:1];

   always_comb begin
      if (!group_ok)
         kind = K_ILLEGAL;
      else if ((opcode & 8'hF0) == SETBIT_BASE)
         kind = K_SETBIT;
      else if ((opcode & 8'hF0) == BRANCH_BASE)
         kind = K_BRANCH;
      else
         kind = K_ILLEGAL;
   end

endmodule

// File: rtl/bitop_ea.sv
module bitop_ea #(
   parameter int         ADDR_W       = 10,
   parameter logic [7:0] IDX_DATA_LOC = 8'h0E
) (
   input  logic [7:0]        dir_addr,
   input  logic [7:0]        idx_val,
   output logic [ADDR_W-1:0] eff_addr
);

   logic [7:0] sel_byte;

   // Redirection through the index register (R6); every other value,
   // including the index register location itself, passes through (R7)
   assign sel_byte = (dir_addr == IDX_DATA_LOC) ? idx_val : dir_addr;

   generate
      if (ADDR_W == 8) begin : g_narrow
         assign eff_addr = sel_byte;
      end else begin : g_wide
         assign eff_addr = {{(ADDR_W-8){1'b0}}, sel_byte};
      end
   endgenerate

endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
   import bitop_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  bitop_kind_t       kind,
   input  logic [2:0]        bit_idx,
   input  logic [ADDR_W-1:0] pc,
   input  logic [7:0]        offset,
   input  logic [7:0]        data,
   input  logic              c_prev,
   output logic [ADDR_W-1:0] pc_next,
   output logic              c_next,
   output logic [7:0]        wdata
);

   localparam int LANES = 8;

   logic [LANES-1:0]  mask;
   logic              bit_val;
   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] pc_seq3;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_mask
         assign mask[g] = (bit_idx == g[2:0]);
      end
   endgenerate

   assign bit_val = |(data & mask);
   assign off_ext = ADDR_W'(signed'(offset));
   assign pc_seq3 = pc + ADDR_W'(3);
   assign wdata   = data | mask;

   always_comb begin
      unique case (kind)
         K_BRANCH: begin
            pc_next = bit_val ? (pc_seq3 + off_ext) : pc_seq3;
            c_next  = bit_val;
         end
         K_SETBIT: begin
            pc_next = pc + ADDR_W'(2);
            c_next  = c_prev;
         end
         default: begin
            pc_next = pc;
            c_next  = c_prev;
         end
      endcase
   end

endmodule

// File: rtl/bitop_fsm.sv
module bitop_fsm
   import bitop_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   output bitop_state_t state,
   output logic         accept
);

   bitop_state_t st_q, st_d;

   assign accept = (st_q == ST_IDLE) && start;   // R8: only idle accepts
   assign state  = st_q;

   always_comb begin
      unique case (st_q)
         ST_IDLE:      st_d = start ? ST_FETCH_OP : ST_IDLE;
         ST_FETCH_OP:  st_d = ST_FETCH_DIR;
         ST_FETCH_DIR: st_d = ST_FETCH_OFF;
         ST_FETCH_OFF: st_d = ST_READ_DATA;
         ST_READ_DATA: st_d = ST_FINISH;
         default:      st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int         ADDR_W       = 10,
   parameter logic [7:0] IDX_DATA_LOC = 8'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [7:0]        x_in,
   input  logic              c_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] pc_out,
   output logic              c_out,
   output logic              illegal
);

   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr_w
         $error("bitop_unit: ADDR_W must lie in 8..16");
      end
   endgenerate

   bitop_state_t      st;
   logic              accept;
   logic [ADDR_W-1:0] pc_q;
   logic [7:0]        x_q;
   logic              c_q;
   logic [7:0]        op_q;
   logic [7:0]        dir_q;
   logic [7:0]        off_q;
   bitop_kind_t       kind;
   logic [2:0]        bit_idx;
   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] pc_next;
   logic              c_next;
   logic [7:0]        wdata;

   bitop_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .state  (st),
      .accept (accept)
   );

   bitop_decode u_dec (
      .opcode  (op_q),
      .kind    (kind),
      .bit_idx (bit_idx)
   );

   bitop_ea #(.ADDR_W(ADDR_W), .IDX_DATA_LOC(IDX_DATA_LOC)) u_ea (
      .dir_addr (dir_q),
      .idx_val  (x_q),
      .eff_addr (eff_addr)
   );

   bitop_exec #(.ADDR_W(ADDR_W)) u_exec (
      .kind    (kind),
      .bit_idx (bit_idx),
      .pc      (pc_q),
      .offset  (off_q),
      .data    (mem_rdata),
      .c_prev  (c_q),
      .pc_next (pc_next),
      .c_next  (c_next),
      .wdata   (wdata)
   );

   // Each byte arrives one cycle after its read was issued
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         x_q   <= '0;
         c_q   <= 1'b0;
         op_q  <= '0;
         dir_q <= '0;
         off_q <= '0;
      end else begin
         if (accept) begin
            pc_q <= pc_in;
            x_q  <= x_in;
            c_q  <= c_in;
         end
         if (st == ST_FETCH_DIR) op_q  <= mem_rdata;
         if (st == ST_FETCH_OFF) dir_q <= mem_rdata;
         if (st == ST_READ_DATA) off_q <= mem_rdata;
      end
   end

   // Address and strobe schedule (R1, R5, R9, R10)
   always_comb begin
      mem_addr = pc_q;
      mem_rd   = 1'b0;
      unique case (st)
         ST_FETCH_OP: begin
            mem_addr = pc_q;
            mem_rd   = 1'b1;
         end
         ST_FETCH_DIR: begin
            mem_addr = pc_q + ADDR_W'(1);
            mem_rd   = 1'b1;
         end
         ST_FETCH_OFF: begin
            mem_addr = pc_q + ADDR_W'(2);
            mem_rd   = (kind == K_BRANCH);
         end
         ST_READ_DATA: begin
            mem_addr = eff_addr;
            mem_rd   = (kind != K_ILLEGAL);
         end
         ST_FINISH: begin
            mem_addr = eff_addr;
         end
         default: ;
      endcase
   end

   assign mem_wr    = (st == ST_FINISH) && (kind == K_SETBIT);
   assign mem_wdata = wdata;
   assign done      = (st == ST_FINISH);
   assign pc_out    = pc_next;
   assign c_out     = c_next;
   assign illegal   = done && (kind == K_ILLEGAL);

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] pc_in,
   input logic              c_in,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              done,
   input logic [ADDR_W-1:0] pc_out,
   input logic              c_out,
   input logic              illegal
);

   logic              busy_c;
   logic [2:0]        cnt_c;
   logic [ADDR_W-1:0] pc_c;
   logic              c_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_c <= 1'b0;
         cnt_c  <= '0;
         pc_c   <= '0;
         c_c    <= 1'b0;
      end else if (!busy_c && start) begin
         busy_c <= 1'b1;
         cnt_c  <= 3'd1;
         pc_c   <= pc_in;
         c_c    <= c_in;
      end else if (busy_c) begin
         if (done) busy_c <= 1'b0;
         if (cnt_c != 3'd7) cnt_c <= cnt_c + 3'd1;
      end
   end

   assert_done_fifth_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_c && cnt_c == 3'd5));

   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_rd_wr_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_write_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> done);

   assert_setbit_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mem_wr) |-> (c_out == c_c && pc_out == pc_c + ADDR_W'(2)));

   assert_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !illegal && !mem_wr && !c_out) |-> (pc_out == pc_c + ADDR_W'(3)));

   assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && illegal) |-> (!mem_wr && pc_out == pc_c && c_out == c_c));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_c |-> !(mem_rd || mem_wr || done));

endmodule

bind bitop_unit bitop_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;

   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;

   typedef struct packed {
      logic [AW-1:0] pc;
      logic          c;
      logic          ill;
      logic          wr;
      logic [AW-1:0] waddr;
      logic [7:0]    wdata;
      logic [2:0]    nrd;
      logic [AW-1:0] rd0;
      logic [AW-1:0] rd1;
      logic [AW-1:0] rd2;
      logic [AW-1:0] rd3;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] pc_in = '0;
   logic [7:0]    x_in = '0;
   logic          c_in = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata = '0;
   logic          done;
   logic [AW-1:0] pc_out;
   logic          c_out, illegal;

   logic [7:0] mem [DEPTH];
   exp_t       sb_q[$];
   string      tag_q[$];
   int         checks = 0;
   int         errors = 0;
   int         cyc = 0;

   always #5 clk = ~clk;

   bitop_unit #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .x_in(x_in),
      .c_in(c_in), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
      .pc_out(pc_out), .c_out(c_out), .illegal(illegal)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_wr) mem[mem_addr] <= mem_wdata;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Driver: loads memory, computes the expected result, pushes it, starts
   task automatic run(input string tag, input logic [AW-1:0] pc,
                      input logic [7:0] x, input logic c,
                      input logic [7:0] op, input logic [7:0] dir,
                      input logic [7:0] off, input logic [7:0] data,
                      input int hold);
      exp_t e;
      logic [AW-1:0] ea;
      logic [7:0] m;
      logic [AW-1:0] p1, p2;
      p1 = pc + AW'(1);
      p2 = pc + AW'(2);
      ea = (dir == 8'h0E) ? AW'(x) : AW'(dir);
      mem[pc] = op;
      mem[p1] = dir;
      mem[p2] = off;
      mem[ea] = data;
      m = 8'h01 << op[3:1];
      e = '0;
      e.c = c;
      e.rd0 = pc;
      e.rd1 = p1;
      if (op[7:5] == 3'b000 && op[0] == 1'b0 && op[4] == 1'b0) begin
         e.nrd = 3'd4; e.rd2 = p2; e.rd3 = ea;
         e.c = |(data & m);
         e.pc = e.c ? (pc + AW'(3) + AW'(signed'(off))) : (pc + AW'(3));
      end else if (op[7:5] == 3'b000 && op[0] == 1'b0) begin
         e.nrd = 3'd3; e.rd2 = ea;
         e.pc = pc + AW'(2);
         e.wr = 1'b1; e.waddr = ea; e.wdata = data | m;
      end else begin
         e.nrd = 3'd2; e.ill = 1'b1; e.pc = pc;
      end
      sb_q.push_back(e);
      tag_q.push_back(tag);
      @(posedge clk); #1;
      start = 1'b1; pc_in = pc; x_in = x; c_in = c;
      repeat (hold) @(posedge clk);
      #1;
      start = 1'b0; pc_in = ~pc; x_in = ~x; c_in = ~c;
      repeat (7) @(posedge clk);
   endtask

   // Monitor: follows each instruction and compares against the queue
   logic active = 1'b0;
   int   cnt = 0;
   int   nrd = 0;
   logic [AW-1:0] rds [4];

   always @(negedge clk) begin
      if (rst_n) begin
         if (!active && start) begin
            active = 1'b1; cnt = 0; nrd = 0;
         end else if (active) begin
            cnt++;
            if (mem_rd) begin
               if (nrd < 4) rds[nrd] = mem_addr;
               nrd++;
            end
            if (mem_wr && !done) chk("R5", "write outside done", 32'(mem_wr), 0);
            if (done) begin
               if (sb_q.size() == 0) begin
                  chk("R8", "unexpected done", 1, 0);
               end else begin
                  exp_t e;
                  string t;
                  e = sb_q.pop_front();
                  t = tag_q.pop_front();
                  chk("R2", {t, " done cycle"}, 32'(cnt), 5);
                  chk(t, "pc_out", 32'(pc_out), 32'(e.pc));
                  chk(t, "c_out", 32'(c_out), 32'(e.c));
                  chk("R9", {t, " illegal"}, 32'(illegal), 32'(e.ill));
                  chk(t, "mem_wr", 32'(mem_wr), 32'(e.wr));
                  if (e.wr) begin
                     chk(t, "write addr", 32'(mem_addr), 32'(e.waddr));
                     chk(t, "write data", 32'(mem_wdata), 32'(e.wdata));
                  end
                  chk("R1", {t, " read count"}, 32'(nrd), 32'(e.nrd));
                  if (nrd == int'(e.nrd)) begin
                     chk("R1", {t, " read 0"}, 32'(rds[0]), 32'(e.rd0));
                     chk("R1", {t, " read 1"}, 32'(rds[1]), 32'(e.rd1));
                     if (nrd > 2) chk("R1", {t, " read 2"}, 32'(rds[2]), 32'(e.rd2));
                     if (nrd > 3) chk("R1", {t, " read 3"}, 32'(rds[3]), 32'(e.rd3));
                  end
               end
               active = 1'b0;
            end
         end else if (mem_rd || mem_wr || done) begin
            chk("R10", "activity while idle", 1, 0);
         end
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", "reset done", 32'(done), 0);
      chk("R10", "reset mem_rd", 32'(mem_rd), 0);
      chk("R10", "reset mem_wr", 32'(mem_wr), 0);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      // test-branch taken / not taken
      run("R3 taken bit0",        10'h100, 8'h00, 1'b0, 8'h00, 8'h40, 8'h05, 8'h01, 1);
      run("R4 not taken bit7",    10'h120, 8'h00, 1'b1, 8'h0E, 8'h41, 8'h10, 8'h7F, 1);
      run("R3 offset -128",       10'h010, 8'h00, 1'b0, 8'h06, 8'h50, 8'h80, 8'h08, 1);
      run("R3 wrap top",          10'h3FE, 8'h00, 1'b0, 8'h02, 8'h60, 8'h04, 8'h02, 1);
      // set-bit
      run("R5 set bit5",          10'h200, 8'h00, 1'b1, 8'h1A, 8'h70, 8'h00, 8'h81, 1);
      run("R5 already set bit2",  10'h210, 8'h00, 1'b0, 8'h14, 8'h71, 8'h00, 8'h04, 1);
      // indexed forms
      run("R6 indexed branch",    10'h150, 8'h90, 1'b0, 8'h08, 8'h0E, 8'hFE, 8'h10, 1);
      run("R6 indexed set bit7",  10'h160, 8'h91, 1'b1, 8'h1E, 8'h0E, 8'h00, 8'h00, 1);
      run("R7 set on index reg",  10'h170, 8'h33, 1'b0, 8'h10, 8'h0F, 8'h00, 8'h32, 1);
      run("R7 test on index reg", 10'h178, 8'h55, 1'b0, 8'h0C, 8'h0F, 8'h07, 8'h40, 1);
      // illegal opcodes
      run("R9 opcode 01",         10'h180, 8'h00, 1'b1, 8'h01, 8'h72, 8'h00, 8'hAA, 1);
      run("R9 opcode 1F",         10'h188, 8'h00, 1'b0, 8'h1F, 8'h73, 8'h00, 8'h55, 1);
      run("R9 opcode 20",         10'h190, 8'h00, 1'b1, 8'h20, 8'h74, 8'h00, 8'h0F, 1);
      // start held high while busy
      run("R8 held start",        10'h1A0, 8'h00, 1'b0, 8'h12, 8'h75, 8'h00, 8'h00, 4);
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk("R8", "scoreboard drained", 32'(sb_q.size()), 0);
      chk("R5", "memory after set", 32'(mem[10'h075]), 32'h02);
      chk("R7", "index loc after set", 32'(mem[10'h00F]), 32'h40);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      while (cyc < 100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule